// File: doc/BRIEF.md
# Down-Counting Compare Interrupt Timer

This block is a 32-bit periodic timer that sits on a simple register bus with address, write data, write strobe and read data. Its counter counts down. At zero it either reloads from a programmable start value or wraps to all ones. One of three clock-enable inputs drives the count through a 12-bit divider. A control code of zero selects no source, and the counter then holds.

Software arms an event by writing a compare value, usually the current count minus the number of ticks it wants to wait. The block raises a sticky flag on the step that brings the counter onto that value. It asserts an interrupt while the flag and its enable are both set, and it can toggle, clear or set an output pin at the same moment. Control words and status use plain registers. The bus has no handshake: a write takes effect at the clock edge where `bus_we` is high, and read data is a combinational decode of the address.

Top module: `dncount_timer`

## Requirements
- R1: After reset, every register reads zero except load (byte offset 0x08) and counter (0x10), which read 0xFFFFFFFF. `irq` and `cmp_pin` are low. The other offsets are control 0x00, status 0x04 and compare 0x0C. Any other offset reads zero.
- R2: The control word has these fields: bit 0 run, bit 1 restart-on-enable, bit 2 interrupt enable, bit 3 reload, bits 15:4 divider, bit 16 soft reset, bit 17 load overwrite, bits 18/19/21 low-power enables, bits 23:22 pin mode and bits 25:24 source. Bit 20 and bits 31:26 always read zero. The low-power bits are stored and have no other effect. Writes to the counter offset are ignored.
- R3: While run is set, the counter decrements once every (divider+1) ticks of the selected source. Source code 1 selects `src_periph_tick`, 2 selects `src_refhi_tick` and 3 selects `src_reflo_tick`. Code 0 freezes the counter. Any control write restarts the divider phase, so the next selected tick steps the counter.
- R4: A step from zero loads the load value when reload is set, and 0xFFFFFFFF when it is clear.
- R5: Status bit 0 sets at the edge where a counter step lands on the compare value. This holds for any 32-bit value, including 0xFFFFFFFF right after a wrap. The flag then stays set.
- R6: Writing 1 to status bit 0 clears the flag, and writing 0 has no effect. A clearing write in the same cycle as a new match leaves the flag set.
- R7: `irq` is high exactly when the flag and the interrupt enable are both set.
- R8: On a match, pin mode 1 toggles the pin state, mode 2 clears it and mode 3 sets it. In mode 0 `cmp_pin` reads low while the stored state is kept.
- R9: With load overwrite set, a load write also copies the value into the counter at the same edge. With it clear, the counter is untouched.
- R10: A control write that turns run from 0 to 1 with restart-on-enable set starts the counter at the load value (reload set) or at 0xFFFFFFFF (reload clear). Without restart-on-enable the counter resumes from its held value.
- R11: Writing soft reset returns all registers, the pin and the divider to their reset values at the following edge. The soft-reset bit itself then reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one register write per high cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| src_periph_tick | input | 1 | Source 1 clock enable |
| src_refhi_tick | input | 1 | Source 2 clock enable |
| src_reflo_tick | input | 1 | Source 3 clock enable |
| irq | output | 1 | Compare interrupt |
| cmp_pin | output | 1 | Compare output pin |

## Verification
The properties assume that the tick inputs are clean single-cycle enables and that no write lands in the cycles a property names as write-free. The freeze and wrap checks, for example, apply only while `bus_we` is low. The stimulus drives every tick as a one-cycle pulse with the bus idle. It issues writes only in cycles apart from steps, with one exception: a deliberate cycle that combines a match step with a flag-clearing write, which the flag property allows for explicitly.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int PRE_W  = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h10;

  // Bits software may hold in the control word (20 and 31:26 stay zero)
  localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h03EF_FFFF;

  typedef enum logic [1:0] {
    PIN_OFF    = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic [5:0]       rsvd_hi;
    logic [1:0]       src_sel;
    pin_mode_e        pin_mode;
    logic             stop_en;
    logic             rsvd20;
    logic             wait_en;
    logic             dbg_en;
    logic             ovw;
    logic             swrst;
    logic [PRE_W-1:0] divider;
    logic             reload;
    logic             irq_en;
    logic             restart_mode;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              match_evt,
  output ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              flag_q,
  output logic              srst,
  output logic              ctrl_wr,
  output logic              restart,
  output logic [DATA_W-1:0] restart_val,
  output logic              ovw_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic wr_stat, wr_load, wr_cmp;

  assign ctrl_wr = bus_we && (bus_addr == OFS_CTRL);
  assign wr_stat = bus_we && (bus_addr == OFS_STAT);
  assign wr_load = bus_we && (bus_addr == OFS_LOAD);
  assign wr_cmp  = bus_we && (bus_addr == OFS_CMP);
  assign srst    = ctrl_q.swrst;

  // run rising through a control write with restart-on-enable requested
  assign restart     = ctrl_wr && bus_wdata[0] && bus_wdata[1] && !ctrl_q.run;
  assign restart_val = bus_wdata[3] ? load_q : '1;
  assign ovw_wr      = wr_load && ctrl_q.ovw;

  always_ff @(posedge clk) begin
    if (!rst_n || srst) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata & CTRL_KEEP);
      if (wr_load) load_q <= bus_wdata;
      if (wr_cmp)  cmp_q  <= bus_wdata;
      if (match_evt)                  flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
      OFS_LOAD: bus_rdata = load_q;
      OFS_CMP:  bus_rdata = cmp_q;
      OFS_CNT:  bus_rdata = cnt_val;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/timer_prescale.sv
module timer_prescale
  import timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             phase_clr,
  input  logic             run,
  input  logic [1:0]       src_sel,
  input  logic [PRE_W-1:0] divider,
  input  logic             tick_a,
  input  logic             tick_b,
  input  logic             tick_c,
  output logic             step
);
  logic [3:0]       src_vec;
  logic             sel_tick;
  logic [PRE_W-1:0] phase_q;

  assign src_vec  = {tick_c, tick_b, tick_a, 1'b0};
  assign sel_tick = run && src_vec[src_sel];
  assign step     = sel_tick && (phase_q == '0) && !phase_clr;

  always_ff @(posedge clk) begin
    if (!rst_n || srst || phase_clr) phase_q <= '0;
    else if (sel_tick)               phase_q <= (phase_q == '0) ? divider : phase_q - 1'b1;
  end
endmodule

// File: rtl/timer_count.sv
module timer_count
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              srst,
  input  logic              step,
  input  logic              reload,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] cmp_val,
  input  logic              restart,
  input  logic [DATA_W-1:0] restart_val,
  input  logic              ovw_wr,
  input  logic [DATA_W-1:0] ovw_val,
  input  pin_mode_e         pin_mode,
  output logic [DATA_W-1:0] cnt_q,
  output logic              match_evt,
  output logic              pin
);
  logic [DATA_W-1:0] cnt_nxt;
  logic              pin_q;

  assign cnt_nxt   = (cnt_q == '0) ? (reload ? load_val : '1) : cnt_q - 1'b1;
  assign match_evt = step && !restart && !ovw_wr && (cnt_nxt == cmp_val);
  assign pin       = (pin_mode != PIN_OFF) && pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n || srst)  cnt_q <= '1;
    else if (restart)    cnt_q <= restart_val;
    else if (ovw_wr)     cnt_q <= ovw_val;
    else if (step)       cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || srst) pin_q <= 1'b0;
    else if (match_evt) begin
      unique case (pin_mode)
        PIN_TOGGLE: pin_q <= !pin_q;
        PIN_CLEAR:  pin_q <= 1'b0;
        PIN_SET:    pin_q <= 1'b1;
        default:    pin_q <= pin_q;
      endcase
    end
  end
endmodule

// File: rtl/dncount_timer.sv
module dncount_timer
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              src_periph_tick,
  input  logic              src_refhi_tick,
  input  logic              src_reflo_tick,
  output logic              irq,
  output logic              cmp_pin
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q, cmp_q, cnt_q, restart_val;
  logic              flag_q, srst, ctrl_wr, restart, ovw_wr, step, match_evt;

  timer_regs u_regs (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we,
    .cnt_val(cnt_q), .match_evt,
    .ctrl_q, .load_q, .cmp_q, .flag_q, .srst, .ctrl_wr,
    .restart, .restart_val, .ovw_wr, .bus_rdata
  );

  timer_prescale u_pre (
    .clk, .rst_n, .srst,
    .phase_clr(ctrl_wr || ovw_wr),
    .run(ctrl_q.run), .src_sel(ctrl_q.src_sel), .divider(ctrl_q.divider),
    .tick_a(src_periph_tick), .tick_b(src_refhi_tick), .tick_c(src_reflo_tick),
    .step
  );

  timer_count u_cnt (
    .clk, .rst_n, .srst, .step,
    .reload(ctrl_q.reload), .load_val(load_q), .cmp_val(cmp_q),
    .restart, .restart_val, .ovw_wr, .ovw_val(bus_wdata),
    .pin_mode(ctrl_q.pin_mode),
    .cnt_q, .match_evt, .pin(cmp_pin)
  );

  assign irq = flag_q && ctrl_q.irq_en;
endmodule

// File: rtl/timer_chk.sv
module timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [4:0]  bus_addr,
  input logic        wbit0,
  input logic [31:0] ctrl,
  input logic [31:0] cnt,
  input logic [31:0] cmp,
  input logic        flag,
  input logic        step,
  input logic        srst
);
  // R5
  flag_rise_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == cmp));

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !srst && !(bus_we && bus_addr == 5'h04 && wbit0)) |=> flag);

  // R3
  frozen_src_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[25:24] == 2'd0 && !bus_we && !srst) |=> $stable(cnt));

  // R4
  wrap_to_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == 32'd0 && !ctrl[3] && !bus_we && !srst) |=> (cnt == 32'hFFFF_FFFF));

  // R11
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (ctrl == 32'd0 && cnt == 32'hFFFF_FFFF && !flag));
endmodule

bind dncount_timer timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .wbit0(bus_wdata[0]), .ctrl(ctrl_q), .cnt(cnt_q), .cmp(cmp_q),
  .flag(flag_q), .step(step), .srst(srst)
);

// File: tb/test_dncount_timer.sv
`timescale 1ns/100ps
module test_dncount_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        tk_p = 1'b0, tk_h = 1'b0, tk_l = 1'b0;
  logic        irq, cmp_pin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 pin
    logic [4:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = !clk;

  dncount_timer i_dncount_timer (
    .clk, .rst_n, .bus_addr, .bus_wdata, .bus_we, .bus_rdata,
    .src_periph_tick(tk_p), .src_refhi_tick(tk_h), .src_reflo_tick(tk_l),
    .irq, .cmp_pin
  );

  // monitor: pops expected items mid-low-phase and compares
  initial forever begin
    @(negedge clk);
    #0.5;
    while (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb.pop_front();
      case (it.kind)
        1:       act = {31'd0, irq};
        2:       act = {31'd0, cmp_pin};
        default: act = bus_rdata;
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h", it.tag, it.kind, it.addr, act, it.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    bus_we = 1'b0;
    sb.push_back('{kind, a, e, tag});
    #1;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    #0.5 bus_we = 1'b0;
  endtask

  task automatic tick(input int n, input int which);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tk_p = (which == 1); tk_h = (which == 2); tk_l = (which == 3);
      @(posedge clk);
      #0.5 {tk_p, tk_h, tk_l} = 3'b000;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(0, 5'h00, 32'h0, "R1 ctrl");
    chk(0, 5'h04, 32'h0, "R1 status");
    chk(0, 5'h08, 32'hFFFF_FFFF, "R1 load");
    chk(0, 5'h0C, 32'h0, "R1 compare");
    chk(0, 5'h10, 32'hFFFF_FFFF, "R1 counter");
    chk(1, 5'h10, 32'h0, "R1 irq");
    chk(2, 5'h10, 32'h0, "R1 pin");
    chk(0, 5'h14, 32'h0, "R1 unmapped");
    // R2 field storage and reserved bits
    wr(5'h00, 32'hFCFE_FFF6);
    chk(0, 5'h00, 32'h00EE_FFF6, "R2 ctrl readback");
    wr(5'h10, 32'h0000_1234);
    chk(0, 5'h10, 32'hFFFF_FFFF, "R2 counter read-only");
    wr(5'h00, 32'h0);
    // R9 overwrite
    wr(5'h00, 32'h0002_0000);
    wr(5'h08, 32'h10);
    chk(0, 5'h10, 32'h10, "R9 overwrite copies");
    wr(5'h00, 32'h0);
    wr(5'h08, 32'h20);
    chk(0, 5'h10, 32'h10, "R9 no overwrite");
    chk(0, 5'h08, 32'h20, "R9 load stored");
    // R3 source selection and divider
    wr(5'h00, 32'h0100_0001);
    tick(3, 1);
    chk(0, 5'h10, 32'h0D, "R3 periph steps");
    tick(2, 2);
    chk(0, 5'h10, 32'h0D, "R3 unselected ignored");
    wr(5'h00, 32'h0200_0001);
    tick(1, 2);
    chk(0, 5'h10, 32'h0C, "R3 refhi");
    wr(5'h00, 32'h0300_0001);
    tick(1, 3);
    chk(0, 5'h10, 32'h0B, "R3 reflo");
    wr(5'h00, 32'h0000_0001);
    tick(1, 1); tick(1, 2); tick(1, 3);
    chk(0, 5'h10, 32'h0B, "R3 source off frozen");
    wr(5'h00, 32'h0100_0021);
    tick(1, 1);
    chk(0, 5'h10, 32'h0A, "R3 divider first tick");
    tick(2, 1);
    chk(0, 5'h10, 32'h0A, "R3 divider hold");
    tick(1, 1);
    chk(0, 5'h10, 32'h09, "R3 divider third");
    // R4 reload, R5 match at zero
    wr(5'h00, 32'h0100_0009);
    tick(9, 1);
    chk(0, 5'h10, 32'h0, "R4 reach zero");
    chk(0, 5'h04, 32'h1, "R5 flag at zero");
    tick(1, 1);
    chk(0, 5'h10, 32'h20, "R4 reload value");
    // R6 write-one-to-clear
    wr(5'h04, 32'h0);
    chk(0, 5'h04, 32'h1, "R6 write zero no effect");
    wr(5'h04, 32'h1);
    chk(0, 5'h04, 32'h0, "R6 write one clears");
    // R4 wrap, R5 match after wrap
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0100_0001);
    tick(32, 1);
    chk(0, 5'h10, 32'h0, "R4 count to zero");
    chk(0, 5'h04, 32'h0, "R5 no early flag");
    tick(1, 1);
    chk(0, 5'h10, 32'hFFFF_FFFF, "R4 wrap");
    chk(0, 5'h04, 32'h1, "R5 flag after wrap");
    chk(1, 5'h04, 32'h0, "R7 irq masked");
    // R6 clear in same cycle as match
    wr(5'h0C, 32'hFFFF_FFFE);
    @(negedge clk);
    bus_addr = 5'h04; bus_wdata = 32'h1; bus_we = 1'b1; tk_p = 1'b1;
    @(posedge clk);
    #0.5 begin bus_we = 1'b0; tk_p = 1'b0; end
    chk(0, 5'h04, 32'h1, "R6 match beats clear");
    chk(0, 5'h10, 32'hFFFF_FFFE, "R6 count moved");
    // R7 interrupt gating
    wr(5'h00, 32'h0100_0005);
    chk(1, 5'h04, 32'h1, "R7 irq on");
    wr(5'h04, 32'h1);
    chk(1, 5'h04, 32'h0, "R7 irq off after clear");
    // R8 pin modes
    wr(5'h00, 32'h0140_0001);
    wr(5'h0C, 32'hFFFF_FFFD);
    tick(1, 1);
    chk(2, 5'h10, 32'h1, "R8 toggle high");
    wr(5'h0C, 32'hFFFF_FFFB);
    tick(2, 1);
    chk(2, 5'h10, 32'h0, "R8 toggle low");
    wr(5'h00, 32'h01C0_0001);
    wr(5'h0C, 32'hFFFF_FFFA);
    tick(1, 1);
    chk(2, 5'h10, 32'h1, "R8 set");
    wr(5'h00, 32'h0100_0001);
    chk(2, 5'h10, 32'h0, "R8 disconnected low");
    wr(5'h00, 32'h0180_0001);
    chk(2, 5'h10, 32'h1, "R8 state retained");
    wr(5'h0C, 32'hFFFF_FFF9);
    tick(1, 1);
    chk(2, 5'h10, 32'h0, "R8 clear");
    // R10 restart-on-enable vs resume
    wr(5'h00, 32'h0);
    wr(5'h00, 32'h0100_000B);
    chk(0, 5'h10, 32'h20, "R10 restart from load");
    tick(2, 1);
    chk(0, 5'h10, 32'h1E, "R10 counting");
    wr(5'h00, 32'h0100_000A);
    wr(5'h00, 32'h0100_0009);
    chk(0, 5'h10, 32'h1E, "R10 resume");
    wr(5'h00, 32'h0100_0008);
    wr(5'h00, 32'h0100_0003);
    chk(0, 5'h10, 32'hFFFF_FFFF, "R10 restart to ones");
    // R11 soft reset
    tick(1, 1);
    wr(5'h0C, 32'h55);
    wr(5'h08, 32'h77);
    wr(5'h00, 32'h0001_0001);
    @(posedge clk);
    chk(0, 5'h00, 32'h0, "R11 ctrl");
    chk(0, 5'h0C, 32'h0, "R11 compare");
    chk(0, 5'h08, 32'hFFFF_FFFF, "R11 load");
    chk(0, 5'h10, 32'hFFFF_FFFF, "R11 counter");
    chk(2, 5'h10, 32'h0, "R11 pin");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule